// File: doc/BRIEF.md
# Pulse-Width Measurement Timer with Noise Filter

This block is an 8-bit down-counter peripheral with two functions. In its timer function it loads a value from a reload buffer and counts it down on each pulse of an external prescaled count clock. It either reloads and keeps going (reload mode) or stops after the first underflow (one-shot mode). In its measurement function it arms at 0xFF and waits for the active edge of an external pulse input. It then counts down until the opposite edge arrives and latches the elapsed tick count into a readable result.

The pulse input passes through a synchronizer and an integrating noise filter before edge detection. Two select bits either bypass the filter or pick one of three sample rates. At the chosen rate, the filtered level only moves once three consecutive samples agree. A completion flag feeds an interrupt request through an enable bit. A separate status bit records a counter wrap during a measurement.

Software reaches the block through a four-register port. Register writes take effect on the clock edge on which they are sampled. Reads are combinational.

Top module: `pulse_span_timer`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is 0.
- R2: One-shot: writing CONTROL (address 0) with bit 7 (run) = 1 and bit 6 (reload mode) = 0 loads the counter from the reload buffer (DATA write, address 2). Each `cnt_tick` then decrements it. A tick while the count is 0 sets the done flag (CONTROL bit 1), clears run and leaves the count at 0.
- R3: Reload mode (CONTROL bit 6 = 1): a tick while the count is 0 reloads the counter from the reload buffer on that tick and sets the done flag. Run stays 1.
- R4: The counter changes only on clock edges where `cnt_tick` is 1. With `cnt_tick` low the count read from DATA holds.
- R5: While run is 1, writes to CONTROL bit 6 and to MODE (address 1) bits 7 and 0 are ignored. The previous values read back.
- R6: Measurement (MODE bit 7 = 1): arming by writing run loads 0xFF. The active input edge starts counting, and that edge's tick counts. At the ending edge the result (0xFF minus the remaining count) is latched, done is set and run is cleared. In this function DATA reads return the result.
- R7: MODE bit 0 = 0 measures a high pulse (rising edge starts, falling edge ends). MODE bit 0 = 1 measures a low pulse.
- R8: A tick at count 0 during a measurement wraps the counter to 0xFF and sets the overflow flag (CONTROL bit 0).
- R9: FILTER (address 3) bits 1:0 = 00 bypass the filter. 01, 10 and 11 sample every clock, every 4 clocks and every 16 clocks. The filtered level changes only after three consecutive samples agree, so shorter pulses are rejected.
- R10: Writing 0 to CONTROL bit 1 or bit 0 clears that flag, and writing 1 leaves it. `irq` is high exactly when CONTROL bit 5 (interrupt enable) and the done flag are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pulse_in | input | 1 | Raw pulse input to be measured |
| cnt_tick | input | 1 | Prescaled count-clock enable |
| irq | output | 1 | Interrupt request |

## Verification
A register write lands on the edge that samples it. Timer results therefore follow from that edge: after a load of N, the count reaches 0 on the Nth tick and done appears one tick later. In bypass, an input change reaches the edge detector two clocks after it is sampled, and the latched result is readable one clock after the ending edge is seen. The every-clock filter adds four more clocks to both edges, so it leaves the measured width unchanged. The bench drives stimulus on falling edges, counts the exact number of edges to each expected change, and samples one clock before and one clock after for the timer flags. For the measurement results it waits a fixed margin that is longer than the worst filter delay before reading.

// File: rtl/pst_pkg.sv
package pst_pkg;
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_MODE = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;
   localparam logic [1:0] ADDR_FILT = 2'd3;

   typedef enum logic [1:0] {
      MS_IDLE  = 2'd0,
      MS_ARMED = 2'd1,
      MS_COUNT = 2'd2
   } meas_state_t;
endpackage

// File: rtl/pst_noise_filter.sv
module pst_noise_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AGREE       = 3,
   parameter int unsigned DIV_MID     = 4,
   parameter int unsigned DIV_SLOW    = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       raw,
   output logic       filt
);
   localparam int unsigned PW = $clog2(DIV_SLOW);
   localparam int unsigned MW = $clog2(DIV_MID);

   initial begin
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert (AGREE >= 2) else $error("AGREE must be at least 2");
      assert ((DIV_MID >= 2) && ((1 << MW) == DIV_MID)) else $error("DIV_MID must be a power of two");
      assert ((DIV_SLOW > DIV_MID) && ((1 << PW) == DIV_SLOW)) else $error("DIV_SLOW must be a larger power of two");
   end

   logic             synced;
   logic [PW-1:0]    pre_q;
   logic             strobe;
   logic [AGREE-1:0] hist_q;
   logic             out_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= raw;
         assign synced = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[SYNC_STAGES-2:0], raw};
         assign synced = s_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;

   always_comb begin
      unique case (sel)
         2'b01:   strobe = 1'b1;
         2'b10:   strobe = (pre_q[MW-1:0] == '0);
         2'b11:   strobe = (pre_q == '0);
         default: strobe = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         out_q  <= 1'b0;
      end else begin
         if (strobe) hist_q <= {hist_q[AGREE-2:0], synced};
         if (&hist_q)       out_q <= 1'b1;
         else if (~|hist_q) out_q <= 1'b0;
      end
   end

   assign filt = (sel == 2'b00) ? synced : out_q;

   // R9: the integrated level moves only after all samples agreed on the new value
   p_filter_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q != $past(out_q)) |-> ($past(hist_q) == {AGREE{out_q}}));
endmodule

// File: rtl/pst_edge_detect.sv
module pst_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   input  logic invert,
   output logic start_edge,
   output logic end_edge
);
   logic act;
   logic prev_q;

   assign act = level_in ^ invert;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= act;

   assign start_edge = act & ~prev_q;
   assign end_edge   = ~act & prev_q;

   // R7: a start and an end cannot be reported on the same cycle
   p_edge_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_edge, end_edge}));
endmodule

// File: rtl/pst_count_core.sv
module pst_count_core
   import pst_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          run,
   input  logic          arm,
   input  logic          measure,
   input  logic          reload_mode,
   input  logic [DW-1:0] reload_val,
   input  logic          start_edge,
   input  logic          end_edge,
   output logic [DW-1:0] count,
   output logic [DW-1:0] result,
   output logic          tmr_underflow,
   output logic          meas_wrap,
   output logic          meas_done
);
   localparam logic [DW-1:0] ALL1 = '1;

   initial assert (DW >= 2) else $error("DW must be at least 2");

   meas_state_t   state_q;
   logic [DW-1:0] cnt_q;
   logic [DW-1:0] res_q;
   logic          at_zero;

   assign at_zero = (cnt_q == '0);

   assign tmr_underflow = run & ~arm & ~measure & tick & at_zero;
   assign meas_done     = run & ~arm & measure & (state_q == MS_COUNT) & end_edge;
   assign meas_wrap     = run & ~arm & measure & (state_q == MS_COUNT) & ~end_edge & tick & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MS_IDLE;
         cnt_q   <= '0;
         res_q   <= '0;
      end else if (arm) begin
         cnt_q   <= measure ? ALL1 : reload_val;
         state_q <= measure ? MS_ARMED : MS_IDLE;
      end else if (!run) begin
         state_q <= MS_IDLE;
      end else if (measure) begin
         unique case (state_q)
            MS_ARMED: if (start_edge) begin
               state_q <= MS_COUNT;
               if (tick) cnt_q <= ALL1 - 1'b1;
            end
            MS_COUNT: if (end_edge) begin
               res_q   <= ALL1 - cnt_q;
               state_q <= MS_IDLE;
            end else if (tick) begin
               cnt_q <= at_zero ? ALL1 : cnt_q - 1'b1;
            end
            default: state_q <= MS_IDLE;
         endcase
      end else if (tick) begin
         if (!at_zero)         cnt_q <= cnt_q - 1'b1;
         else if (reload_mode) cnt_q <= reload_val;
      end
   end

   assign count  = cnt_q;
   assign result = res_q;

   // R3: an underflow in reload mode restores the buffered value
   p_reload_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_underflow && reload_mode) |=> (cnt_q == $past(reload_val)));
   // R2: an underflow in one-shot mode leaves the count parked at zero
   p_oneshot_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_underflow && !reload_mode) |=> (cnt_q == '0));
   // R6: arming a measurement starts from all ones and waits for an edge
   p_arm_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && measure) |=> (cnt_q == ALL1) && (state_q == MS_ARMED));
   // R4: without a tick and without arming the count holds
   p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !arm) |=> $stable(cnt_q));
   // R8: a wrap during measurement lands on all ones
   p_wrap_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      meas_wrap |=> (cnt_q == ALL1));
endmodule

// File: rtl/pulse_span_timer.sv
module pulse_span_timer
   import pst_pkg::*;
#(
   parameter int unsigned REG_W       = 8,
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AGREE       = 3,
   parameter int unsigned DIV_MID     = 4,
   parameter int unsigned DIV_SLOW    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             pulse_in,
   input  logic             cnt_tick,
   output logic             irq
);
   initial assert ((REG_W == 8) && (DW <= REG_W)) else $error("register width must be 8 and hold the counter");

   logic          run_q, reload_mode_q, irq_en_q, done_q, wrap_q;
   logic          measure_q, low_pulse_q;
   logic [1:0]    fsel_q;
   logic [DW-1:0] reload_q;

   logic          wr_ctrl, wr_mode, wr_data, wr_filt;
   logic          arm, finish;
   logic          filt;
   logic          start_edge, end_edge;
   logic [DW-1:0] count, result;
   logic          tmr_uf, meas_wrap, meas_done;
   logic          unused_wbits;

   assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
   assign wr_mode = reg_wr && (reg_addr == ADDR_MODE);
   assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
   assign wr_filt = reg_wr && (reg_addr == ADDR_FILT);

   assign arm    = wr_ctrl && reg_wdata[7] && !run_q;
   assign finish = (tmr_uf && !reload_mode_q) || meas_done;
   assign unused_wbits = ^reg_wdata[4:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q         <= 1'b0;
         reload_mode_q <= 1'b0;
         irq_en_q      <= 1'b0;
         done_q        <= 1'b0;
         wrap_q        <= 1'b0;
         measure_q     <= 1'b0;
         low_pulse_q   <= 1'b0;
         fsel_q        <= 2'b00;
         reload_q      <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q    <= reg_wdata[7];
            irq_en_q <= reg_wdata[5];
            if (!run_q) reload_mode_q <= reg_wdata[6];
            done_q   <= (done_q & reg_wdata[1]) | tmr_uf | meas_done;
            wrap_q   <= (wrap_q & reg_wdata[0]) | meas_wrap;
         end else begin
            done_q   <= done_q | tmr_uf | meas_done;
            wrap_q   <= wrap_q | meas_wrap;
         end
         if (finish && !arm) run_q <= 1'b0;
         if (wr_mode && !run_q) begin
            measure_q   <= reg_wdata[7];
            low_pulse_q <= reg_wdata[0];
         end
         if (wr_data) reload_q <= reg_wdata[DW-1:0];
         if (wr_filt) fsel_q   <= reg_wdata[1:0];
      end
   end

   pst_noise_filter #(
      .SYNC_STAGES(SYNC_STAGES), .AGREE(AGREE), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
   ) u_filter (
      .clk(clk), .rst_n(rst_n), .sel(fsel_q), .raw(pulse_in), .filt(filt)
   );

   pst_edge_detect u_edge (
      .clk(clk), .rst_n(rst_n), .level_in(filt), .invert(low_pulse_q),
      .start_edge(start_edge), .end_edge(end_edge)
   );

   pst_count_core #(.DW(DW)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .run(run_q), .arm(arm),
      .measure(measure_q), .reload_mode(reload_mode_q), .reload_val(reload_q),
      .start_edge(start_edge), .end_edge(end_edge),
      .count(count), .result(result),
      .tmr_underflow(tmr_uf), .meas_wrap(meas_wrap), .meas_done(meas_done)
   );

   always_comb begin
      unique case (reg_addr)
         ADDR_CTRL: reg_rdata = {run_q, reload_mode_q, irq_en_q, 3'b000, done_q, wrap_q};
         ADDR_MODE: reg_rdata = {measure_q, 6'b000000, low_pulse_q};
         ADDR_DATA: reg_rdata = measure_q ? REG_W'(result) : REG_W'(count);
         default:   reg_rdata = {6'b000000, fsel_q};
      endcase
   end

   assign irq = irq_en_q & done_q;

   // R5: configuration bits cannot move while the counter runs
   p_mode_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q)) |-> ($stable(reload_mode_q) && $stable(measure_q) && $stable(low_pulse_q)));
   // R10: the request never rises without a pending done flag
   p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done_q);
   // R8: the wrap status only appears in the measurement function
   p_wrap_measure_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrap_q) |-> measure_q);
   // R2: a one-shot underflow stops the counter
   p_oneshot_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_uf && !reload_mode_q && !wr_ctrl) |=> !run_q);
endmodule

// File: tb/tb_pulse_span_timer.sv
`timescale 1ns/1ps
module tb_pulse_span_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       pulse_in = 1'b0;
   logic       cnt_tick = 1'b1;
   logic       irq;

   int n_checks = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   pulse_span_timer dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pulse_in(pulse_in),
      .cnt_tick(cnt_tick), .irq(irq)
   );

   typedef struct packed {
      logic [15:0] width;
      logic [1:0]  sel;
      logic [7:0]  res;
      logic        wrap;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{16'd10,  2'd0, 8'd10,  1'b0},
      '{16'd1,   2'd0, 8'd1,   1'b0},
      '{16'd255, 2'd0, 8'd255, 1'b0},
      '{16'd256, 2'd0, 8'd0,   1'b1},
      '{16'd300, 2'd0, 8'd44,  1'b1},
      '{16'd20,  2'd1, 8'd20,  1'b0},
      '{16'd40,  2'd1, 8'd40,  1'b0}
   };

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int width, input logic idle);
      pulse_in = ~idle;
      wait_n(width);
      pulse_in = idle;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         check("R1 reset register", d, 0);
      end
      check("R1 reset irq", irq, 0);

      // R2 one-shot with R4 tick gating
      wr(2'd2, 8'd10);
      wr(2'd0, 8'h80);
      cnt_tick = 1'b0;
      wait_n(5);
      rd(2'd2, d); check("R4 count held without tick", d, 10);
      cnt_tick = 1'b1;
      wait_n(3);
      rd(2'd2, d); check("R4 count after 3 ticks", d, 7);
      wait_n(7);
      rd(2'd2, d); check("R2 count reaches zero", d, 0);
      rd(2'd0, d); check("R2 done not yet", d, 8'h80);
      wait_n(1);
      rd(2'd0, d); check("R2 done set, run cleared", d, 8'h02);
      rd(2'd2, d); check("R2 count parked at zero", d, 0);
      wait_n(3);
      rd(2'd2, d); check("R2 stays stopped", d, 0);

      // R3 reload mode
      wr(2'd0, 8'h00);
      wr(2'd2, 8'd3);
      wr(2'd0, 8'hC0);
      rd(2'd2, d); check("R3 loaded", d, 3);
      wait_n(3);
      rd(2'd2, d); check("R3 at zero", d, 0);
      rd(2'd0, d); check("R3 done not yet", d, 8'hC0);
      wait_n(1);
      rd(2'd2, d); check("R3 reloaded on underflow tick", d, 3);
      rd(2'd0, d); check("R3 done set, still running", d, 8'hC2);

      // R10 flag clear and interrupt
      wr(2'd0, 8'hE0);
      rd(2'd0, d); check("R10 done cleared by 0", d, 8'hE0);
      check("R10 irq low after clear", irq, 0);
      wait_n(3);
      check("R10 irq with enable and done", irq, 1);
      wr(2'd0, 8'h02);
      rd(2'd0, d); check("R10 write 1 keeps done, R5 reload bit kept", d, 8'h42);
      check("R10 irq masked", irq, 0);

      // R5 configuration locked while running
      wr(2'd0, 8'hC0);
      wr(2'd0, 8'h80);
      rd(2'd0, d); check("R5 reload bit ignored while running", d, 8'hC0);
      wr(2'd1, 8'h81);
      rd(2'd1, d); check("R5 mode write ignored while running", d, 0);
      wr(2'd0, 8'h00);

      // R6 R8 R9 table of measurements
      for (int i = 0; i < NV; i++) begin
         wr(2'd0, 8'h00);
         wr(2'd3, {6'b0, VECS[i].sel});
         wr(2'd1, 8'h80);
         wr(2'd0, 8'h80);
         wait_n(2);
         pulse(int'(VECS[i].width), 1'b0);
         wait_n(10);
         rd(2'd0, d); check($sformatf("R6 R8 flags vector %0d", i), d, 8'h02 | 8'(VECS[i].wrap));
         rd(2'd2, d); check($sformatf("R6 R9 result vector %0d", i), d, VECS[i].res);
      end

      // R7 low pulse
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h00);
      pulse_in = 1'b1;
      wait_n(4);
      wr(2'd1, 8'h81);
      wr(2'd0, 8'h80);
      wait_n(2);
      pulse(12, 1'b1);
      wait_n(6);
      rd(2'd0, d); check("R7 low pulse done", d, 8'h02);
      rd(2'd2, d); check("R7 low pulse width", d, 12);
      pulse_in = 1'b0;
      wait_n(4);

      // R9 glitch rejection at the three sample rates
      for (int s = 1; s < 4; s++) begin
         wr(2'd0, 8'h00);
         wr(2'd1, 8'h80);
         wr(2'd3, 8'(s));
         wait_n(40);
         wr(2'd0, 8'h80);
         wait_n(2);
         pulse((s == 1) ? 2 : ((s == 2) ? 2 : 6), 1'b0);
         wait_n(40);
         rd(2'd0, d); check($sformatf("R9 glitch rejected sel %0d", s), d, 8'h80);
      end

      // R9 coarse sampling still measures a long pulse approximately
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h02);
      wr(2'd0, 8'h80);
      wait_n(2);
      pulse(40, 1'b0);
      wait_n(30);
      rd(2'd2, d); check("R9 sel 10 width within one sample", int'(d >= 36 && d <= 44), 1);
      rd(2'd0, d); check("R9 sel 10 done", d, 8'h02);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule